// File: doc/BRIEF.md
# Secure-Mode Watchdog Timer

This block is a countdown watchdog that only secure firmware can program. It is reached over a simple word-wide register bus with separate read and write strobes and a secure-mode qualifier. Firmware writes a tick count into the low half of the timer word. That write starts the countdown, and a later write reloads it, so firmware uses repeated writes as its keep-alive. A read of the same word returns the ticks still remaining in the upper half.

A prescaler divides the core clock into ticks. The default divider gives a tick of about 1.2207 ms (819.2 Hz) from a 50 MHz clock. When the count reaches zero, the counter stops and a sticky timeout flag is set in a separate status word. The interrupt output follows that flag. The status word also keeps a sticky flag raised by a firmware-call event input. Secure firmware clears either flag by writing a one to its bit. A read of the status word from non-secure mode returns no data and pulses an access-fault output instead.

Top module: `secure_wdog_unit`

## Requirements
- R1: After reset the timer is idle, a secure read of the timer word returns 0, the status word reads 0, and `irq_o` and `acc_fault_o` are low.
- R2: A secure write to the timer word (`bus_addr` = 1) loads bits 15:0 as the tick count and starts the countdown. Bits 31:16 of that write are ignored.
- R3: Read data is registered. `bus_rdata` in the cycle after a read strobe holds the remaining count in bits 31:16 and zero in bits 15:0 for the timer word, or the status word zero-extended. A cycle without a read strobe returns 0.
- R4: One tick lasts PRESCALE core cycles, and the count drops by exactly one per tick. After loading N > 0 at clock edge E0, the count equals N − floor(j/PRESCALE) after edge E(j), and the timeout is set at edge E(N·PRESCALE).
- R5: A secure write while the timer is counting reloads the count and restarts the prescaler phase, so the new expiry is timed from that write alone.
- R6: On expiry the count stays at 0 until the next secure write. Status bit 3 is set and `irq_o` goes high and stays high.
- R7: Status bit 3 is cleared only by a secure write to the status word (`bus_addr` = 0) with bit 3 set. A reload of the timer or a write of zero to that bit leaves it set.
- R8: A non-secure read of the status word pulses `acc_fault_o` for one cycle, together with `bus_rdata` = 0. Secure reads of the status word and any read of the timer word raise no fault.
- R9: Non-secure writes have no effect: they neither load the timer nor clear status bits.
- R10: A one-cycle pulse on `call_evt_i` sets status bit 2, which stays set until a secure write with bit 2 set clears it. Bits 7:4 and the other status bits read 0.
- R11: Loading a count of zero sets the timeout at the write's own clock edge and leaves the timer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_secure | input | 1 | High when the access comes from secure mode |
| bus_addr | input | ADDR_W (2) | Word select: 0 status word, 1 timer word |
| bus_wdata | input | DATA_W (32) | Write data |
| call_evt_i | input | 1 | Firmware-call event, sets status bit 2 |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Watchdog timeout interrupt, a level |
| acc_fault_o | output | 1 | Access-fault pulse for a non-secure status read |

## Verification
The hardest situation to reach is a reload that lands in the middle of a prescaler period. If the phase were not restarted, the next expiry would come early by a fraction of a tick, and that error only shows at one exact cycle. The bench runs a timer partway into a tick, then rewrites a short count. It then reads the timer word on every cycle up to and past the new expiry, and compares each value and the interrupt level against the closed-form count. The same per-cycle sweep runs over several load values with a small divider, and a separate write of zero covers expiry on the load edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register word indices on the bus
   localparam int unsigned STATUS_IDX = 0;
   localparam int unsigned TIMER_IDX  = 1;

   // status word layout
   localparam int unsigned STAT_W       = 8;
   localparam int unsigned BIT_CALL     = 2;
   localparam int unsigned BIT_TIMEOUT  = 3;
   localparam int unsigned NUM_FLAGS    = 2;

   typedef struct packed {
      logic timeout;
      logic call;
   } wdog_flags_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned PRESCALE = 61035
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick_o
);
   localparam int unsigned PH_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("wdog_prescaler: PRESCALE must be at least 1");
      end

      if (PRESCALE == 1) begin : g_direct
         assign tick_o = run & ~restart;
      end else begin : g_div
         localparam logic [PH_W-1:0] LAST = PH_W'(PRESCALE - 1);
         logic [PH_W-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (restart || !run) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick_o = run & ~restart & (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_o,
   output logic             running_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("wdog_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             last_tick;
   logic             zero_load;

   assign last_tick = tick & run_q & (cnt_q == ONE) & ~load;
   assign zero_load = load & (load_val == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= (load_val != '0);
      end else if (tick && run_q) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) begin
            run_q <= 1'b0;
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign running_o = run_q;
   assign expire_o  = last_tick | zero_load;
endmodule

// File: rtl/wdog_status.sv
module wdog_status
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_timeout,
   input  logic              set_call,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_mask,
   output logic [STAT_W-1:0] stat_o
);
   localparam int unsigned FLAG_POS [NUM_FLAGS] = '{BIT_CALL, BIT_TIMEOUT};

   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_q;

   assign flag_set = {set_timeout, set_call};

   generate
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
         if (FLAG_POS[f] >= STAT_W) begin : g_bad_pos
            $error("wdog_status: flag position outside status word");
         end
         // set wins over a clear in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q[f] <= 1'b0;
            end else if (flag_set[f]) begin
               flag_q[f] <= 1'b1;
            end else if (clr_wr && clr_mask[FLAG_POS[f]]) begin
               flag_q[f] <= 1'b0;
            end
         end
      end
   endgenerate

   always_comb begin
      stat_o = '0;
      for (int f = 0; f < NUM_FLAGS; f++) begin
         stat_o[FLAG_POS[f]] = flag_q[f];
      end
   end
endmodule

// File: rtl/secure_wdog_unit.sv
module secure_wdog_unit
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRESCALE = 61035
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_secure,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              call_evt_i,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              acc_fault_o
);
   localparam int unsigned HALF_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("secure_wdog_unit: DATA_W must be even");
      end
      if (CNT_W > HALF_W) begin : g_bad_cnt
         $error("secure_wdog_unit: CNT_W must fit in half a word");
      end
      if (STAT_W > HALF_W) begin : g_bad_stat
         $error("secure_wdog_unit: status word wider than half a word");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("secure_wdog_unit: ADDR_W must be at least 1");
      end
   endgenerate

   // bus decode
   logic sel_stat, sel_tmr, wr_sec;
   logic timer_load, stat_clr_wr;

   assign sel_stat    = (bus_addr == ADDR_W'(STATUS_IDX));
   assign sel_tmr     = (bus_addr == ADDR_W'(TIMER_IDX));
   assign wr_sec      = bus_wr & bus_secure;
   assign timer_load  = wr_sec & sel_tmr;
   assign stat_clr_wr = wr_sec & sel_stat;

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

   // datapath
   logic             tick;
   logic             running;
   logic             expire;
   logic [CNT_W-1:0] cnt_q;
   logic [STAT_W-1:0] stat_vec;

   wdog_prescaler #(
      .PRESCALE (PRESCALE)
   ) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (timer_load),
      .run     (running),
      .tick_o  (tick)
   );

   wdog_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (timer_load),
      .load_val  (bus_wdata[CNT_W-1:0]),
      .tick      (tick),
      .cnt_o     (cnt_q),
      .running_o (running),
      .expire_o  (expire)
   );

   wdog_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_timeout (expire),
      .set_call    (call_evt_i),
      .clr_wr      (stat_clr_wr),
      .clr_mask    (bus_wdata[STAT_W-1:0]),
      .stat_o      (stat_vec)
   );

   // read path
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (bus_secure) begin
         if (sel_stat) begin
            rd_mux = DATA_W'(stat_vec);
         end else if (sel_tmr) begin
            rd_mux = DATA_W'(cnt_q) << HALF_W;
         end
      end
   end

   logic [DATA_W-1:0] rdata_q;
   logic              fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         fault_q <= 1'b0;
      end else begin
         rdata_q <= bus_rd ? rd_mux : '0;
         fault_q <= bus_rd & ~bus_secure & sel_stat;
      end
   end

   assign bus_rdata   = rdata_q;
   assign acc_fault_o = fault_q;
   assign irq_o       = stat_vec[BIT_TIMEOUT];
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_secure,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_o,
   input logic              acc_fault_o,
   input logic [CNT_W-1:0]  cnt,
   input logic              running
);
   logic wr_tmr, wr_stat;
   assign wr_tmr  = bus_wr & bus_secure & (bus_addr == ADDR_W'(TIMER_IDX));
   assign wr_stat = bus_wr & bus_secure & (bus_addr == ADDR_W'(STATUS_IDX));

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_tmr && running) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_tmr && !running) |=> $stable(cnt));

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(wr_stat && bus_wdata[BIT_TIMEOUT])) |=> irq_o);

   // R8
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault_o |-> $past(bus_rd && !bus_secure && (bus_addr == ADDR_W'(STATUS_IDX))));

   // R8
   fault_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault_o |-> (bus_rdata == '0));

   // R9
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(bus_wr && bus_secure));
endmodule

bind secure_wdog_unit wdog_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_wdog_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_secure  (bus_secure),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .irq_o       (irq_o),
   .acc_fault_o (acc_fault_o),
   .cnt         (cnt_q),
   .running     (running)
);

// File: tb/test_secure_wdog_unit.sv
`timescale 1ns/1ps
module test_secure_wdog_unit;
   localparam int P = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_secure = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic        call_evt_i = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        acc_fault_o;

   int errs = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   secure_wdog_unit #(.PRESCALE(P)) i_secure_wdog_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_secure  (bus_secure),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .call_evt_i  (call_evt_i),
      .bus_rdata   (bus_rdata),
      .irq_o       (irq_o),
      .acc_fault_o (acc_fault_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input logic sec);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_secure = sec;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_secure = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, input logic sec,
                           output logic [31:0] d, output logic f);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a; bus_secure = sec;
      @(posedge clk);
      @(negedge clk);
      d = bus_rdata; f = acc_fault_o;
      bus_rd = 1'b0; bus_secure = 1'b0;
   endtask

   // per-cycle sweep right after a timer write of n (write edge E0)
   task automatic sweep(input int n, input string req);
      bus_rd = 1'b1; bus_addr = 2'd1; bus_secure = 1'b1;
      for (int c = 1; c <= n * P + 2; c++) begin
         int ec;
         @(posedge clk);
         @(negedge clk);
         ec = n - (c - 1) / P;
         if (ec < 0) ec = 0;
         chk(req, bus_rdata, 32'(ec) << 16);
         chk(req, {31'b0, irq_o}, {31'b0, c >= n * P});
      end
      bus_rd = 1'b0; bus_secure = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic f;
      int lens [5] = '{1, 2, 3, 5, 8};

      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", {31'b0, irq_o}, 32'd0);
      chk("R1", {31'b0, acc_fault_o}, 32'd0);
      chk("R1", bus_rdata, 32'd0);
      rst_n = 1'b1;
      bus_read(2'd1, 1'b1, d, f); chk("R1", d, 32'd0);
      bus_read(2'd0, 1'b1, d, f); chk("R1", d, 32'd0);

      // R4 / R6 / R7 sweep over load values, upper half noise
      foreach (lens[i]) begin
         bus_write(2'd1, {16'hA5A5 ^ 16'(i), 16'(lens[i])}, 1'b1);
         sweep(lens[i], "R4");
         bus_read(2'd0, 1'b1, d, f); chk("R6", d, 32'h8);
         bus_read(2'd1, 1'b1, d, f); chk("R6", d, 32'd0);
         chk("R6", {31'b0, irq_o}, 32'd1);
         bus_write(2'd0, 32'h8, 1'b1);
         chk("R7", {31'b0, irq_o}, 32'd0);
      end

      // R2 typical start value: upper half ignored
      bus_write(2'd1, 32'h7530C800, 1'b1);
      bus_read(2'd1, 1'b1, d, f); chk("R2", d, 32'hC8000000);
      bus_write(2'd1, 32'hFFFF0004, 1'b1);
      sweep(4, "R2");
      bus_write(2'd0, 32'h8, 1'b1);

      // R5 reload mid-tick restarts the phase
      bus_write(2'd1, 32'd4, 1'b1);
      repeat (5) @(posedge clk);
      bus_write(2'd1, 32'd2, 1'b1);
      sweep(2, "R5");
      repeat (10) @(posedge clk);
      bus_read(2'd1, 1'b1, d, f); chk("R6", d, 32'd0);
      chk("R6", {31'b0, irq_o}, 32'd1);

      // R7 reload and zero write do not clear the flag
      bus_write(2'd1, 32'd9, 1'b1);
      bus_read(2'd0, 1'b1, d, f); chk("R7", d, 32'h8);
      bus_write(2'd0, 32'h0, 1'b1);
      bus_read(2'd0, 1'b1, d, f); chk("R7", d, 32'h8);

      // R11 zero load expires on its own edge
      bus_write(2'd0, 32'h8, 1'b1);
      chk("R7", {31'b0, irq_o}, 32'd0);
      bus_write(2'd1, 32'd0, 1'b1);
      chk("R11", {31'b0, irq_o}, 32'd1);
      bus_read(2'd1, 1'b1, d, f); chk("R11", d, 32'd0);
      bus_write(2'd0, 32'h8, 1'b1);

      // R9 non-secure writes ignored
      bus_write(2'd1, 32'd5, 1'b0);
      bus_read(2'd1, 1'b1, d, f); chk("R9", d, 32'd0);
      repeat (20) @(posedge clk);
      chk("R9", {31'b0, irq_o}, 32'd0);
      bus_write(2'd1, 32'd0, 1'b1);
      bus_write(2'd0, 32'h8, 1'b0);
      bus_read(2'd0, 1'b1, d, f); chk("R9", d, 32'h8);
      bus_write(2'd0, 32'h8, 1'b1);

      // R8 access fault
      bus_read(2'd0, 1'b0, d, f);
      chk("R8", d, 32'd0);
      chk("R8", {31'b0, f}, 32'd1);
      @(negedge clk);
      chk("R8", {31'b0, acc_fault_o}, 32'd0);
      bus_read(2'd0, 1'b1, d, f); chk("R8", {31'b0, f}, 32'd0);
      bus_read(2'd1, 1'b0, d, f); chk("R8", {31'b0, f}, 32'd0);
      chk("R3", d, 32'd0);
      @(negedge clk);
      chk("R3", bus_rdata, 32'd0);

      // R10 call flag
      @(negedge clk);
      call_evt_i = 1'b1;
      @(negedge clk);
      call_evt_i = 1'b0;
      bus_read(2'd0, 1'b1, d, f); chk("R10", d, 32'h4);
      bus_write(2'd1, 32'd0, 1'b1);
      bus_read(2'd0, 1'b1, d, f); chk("R10", d, 32'hC);
      bus_write(2'd0, 32'h4, 1'b1);
      bus_read(2'd0, 1'b1, d, f); chk("R10", d, 32'h8);
      bus_write(2'd0, 32'hFF, 1'b1);
      bus_read(2'd0, 1'b1, d, f); chk("R10", d, 32'h0);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule